// File: doc/BRIEF.md
# Strided Line Copy DMA

A copy engine that moves raw 16-byte chunks from a source region to a destination region. Each side has its own line geometry: a number of chunks that are copied contiguously (the line width), followed by a number of chunks that are stepped over (the gap). Because the two sides advance through their line boundaries independently, the engine can lift a sub-rectangle out of one buffer and drop it into a buffer of a different pitch. The gap chunks are never read or written and do not count toward the transfer length.

Software loads the base addresses, the byte total and the two geometries through a small word-addressed register port, then sets the start bit. The engine issues 128-bit read requests on one valid/ready channel, collects the returned chunks in a four-entry buffer and drains them as 128-bit writes on another channel. When the last chunk is written it raises a done flag and pulses an interrupt. Configurations that cannot complete are refused at start and reported as done at once, so a bad setting never hangs the engine.

Top module: `slc_dma`

## Requirements
- R1: After reset the control word reads 0 (busy bit 0 clear, done bit 8 clear), irq_o is low and neither rd_req_valid_o nor wr_valid_o is asserted.
- R2: Register word 0 holds the source byte address shifted right by 3 and word 3 the source geometry (width in bits 15:0, gap in bits 31:16, both in 16-byte chunks). Read request k goes to base + 16*((k/width)*(width+gap) + k%width).
- R3: Register word 1 holds the destination byte address shifted right by 3 and word 4 the destination geometry in the same field layout; write beat k goes to the address given by the R2 formula with the destination values, independent of the source line boundaries.
- R4: Chunk data is written unchanged and in the order it was read: write beat k carries the data returned for read request k.
- R5: Register word 2 holds the byte total; exactly total/16 read requests and total/16 write beats are issued, gap chunks not counted.
- R6: Writing word 5 (control) with bit 0 set while idle starts a transfer: bit 0 reads 1 and bit 8 reads 0 until the last write beat, after which bit 0 clears, bit 8 sets and irq_o is high for exactly one cycle.
- R7: A start with a byte total of zero, a total that is not a multiple of 16, or a zero width on either side sets bit 8 and pulses irq_o in the next cycle with bit 0 staying clear, and issues no read or write.
- R8: A control write with bit 8 = 0 clears the done flag; a control write with bit 8 = 1 leaves it set.
- R9: A start written while a transfer is busy is ignored; the running transfer keeps its beat count.
- R10: At most 4 chunks are requested but not yet written at any time, and a request or write held by a low ready keeps its address and data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | One-cycle completion pulse |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | AW (32) | Read chunk byte address |
| rd_data_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DW (128) | Read chunk data |
| rd_data_ready_o | output | 1 | Chunk buffer can take data |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted |
| wr_addr_o | output | AW (32) | Write chunk byte address |
| wr_data_o | output | DW (128) | Write chunk data |

## Verification
The copy is tried with source and destination geometries that differ in both width and gap, with lines that are longer than the whole transfer, with one-chunk lines, with a single-chunk transfer and with an unaligned base; each set separates a walker that wraps too early or late, that counts gap chunks toward the total, or that couples the two sides. Every read and write address is compared with the closed-form chunk formula and every written word with a data pattern derived from its source address, so misordering or dropping a chunk shows. Half the cases throttle read acceptance, read data and write acceptance on different rhythms to expose buffer overruns and unstable held beats. Directed cases cover each refusal reason, done clearing and a second start during a busy transfer.

// File: rtl/slc_dma_pkg.sv
package slc_dma_pkg;
  localparam int unsigned CHUNK_BYTES = 16;
  localparam int unsigned CHUNK_SHIFT = 4;
  localparam int unsigned GEO_W       = 16;
  localparam int unsigned CTRL_START  = 0;
  localparam int unsigned CTRL_DONE   = 8;

  typedef enum logic [2:0] {
    REG_SRC      = 3'd0,
    REG_DST      = 3'd1,
    REG_TOTAL    = 3'd2,
    REG_SRC_GEOM = 3'd3,
    REG_DST_GEOM = 3'd4,
    REG_CTRL     = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/slc_addr_walk.sv
module slc_addr_walk
  import slc_dma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = GEO_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] width_i,
  input  logic [LW-1:0] gap_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [LW-1:0] width_q, gap_q, col_q;
  logic [AW-1:0] addr_q;
  logic          eol;
  logic [AW-1:0] line_skip;

  assign eol       = (col_q == width_q - LW'(1));
  // step past the last chunk of the line plus all gap chunks
  assign line_skip = AW'({gap_q, 4'b0000}) + AW'(CHUNK_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q <= '0;
      gap_q   <= '0;
      col_q   <= '0;
      addr_q  <= '0;
    end else if (load_i) begin
      width_q <= width_i;
      gap_q   <= gap_i;
      col_q   <= '0;
      addr_q  <= base_i;
    end else if (step_i) begin
      if (eol) begin
        col_q  <= '0;
        addr_q <= addr_q + line_skip;
      end else begin
        col_q  <= col_q + LW'(1);
        addr_q <= addr_q + AW'(CHUNK_BYTES);
      end
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/slc_chunk_fifo.sv
module slc_chunk_fifo #(
  parameter int unsigned DW    = 128,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o = mem_q[rp_q];
endmodule

// File: rtl/slc_dma.sv
module slc_dma
  import slc_dma_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 128,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          irq_o,
  output logic          rd_req_valid_o,
  input  logic          rd_req_ready_i,
  output logic [AW-1:0] rd_req_addr_o,
  input  logic          rd_data_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_data_ready_o,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int unsigned BW  = AW - 3;
  localparam int unsigned CNW = 32 - CHUNK_SHIFT;
  localparam int unsigned CRW = $clog2(FIFO_DEPTH + 1);

  logic [BW-1:0]  src_q, dst_q;
  logic [31:0]    total_q, sgeo_q, dgeo_q;
  logic           busy_q, done_q, irq_q;
  logic [CNW-1:0] rd_left_q, wr_left_q;
  logic [CRW-1:0] credit_q;

  logic ctrl_wr, start_req, bad_cfg;
  logic rd_fire, wr_fire, last_wr;
  logic fifo_full, fifo_empty;

  assign ctrl_wr   = reg_we_i && (reg_addr_i == REG_CTRL);
  assign start_req = ctrl_wr && reg_wdata_i[CTRL_START] && !busy_q;
  assign bad_cfg   = (total_q[CHUNK_SHIFT-1:0] != '0) || (total_q == '0) ||
                     (sgeo_q[GEO_W-1:0] == '0) || (dgeo_q[GEO_W-1:0] == '0);

  // register file
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      dst_q   <= '0;
      total_q <= '0;
      sgeo_q  <= '0;
      dgeo_q  <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        REG_SRC:      src_q   <= reg_wdata_i[BW-1:0];
        REG_DST:      dst_q   <= reg_wdata_i[BW-1:0];
        REG_TOTAL:    total_q <= reg_wdata_i;
        REG_SRC_GEOM: sgeo_q  <= reg_wdata_i;
        REG_DST_GEOM: dgeo_q  <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_SRC:      reg_rdata_o = 32'(src_q);
      REG_DST:      reg_rdata_o = 32'(dst_q);
      REG_TOTAL:    reg_rdata_o = total_q;
      REG_SRC_GEOM: reg_rdata_o = sgeo_q;
      REG_DST_GEOM: reg_rdata_o = dgeo_q;
      REG_CTRL: begin
        reg_rdata_o[CTRL_START] = busy_q;
        reg_rdata_o[CTRL_DONE]  = done_q;
      end
      default: ;
    endcase
  end

  // transfer control
  assign rd_req_valid_o = busy_q && (rd_left_q != '0) && (credit_q < CRW'(FIFO_DEPTH));
  assign rd_fire        = rd_req_valid_o && rd_req_ready_i;
  assign wr_valid_o     = busy_q && !fifo_empty;
  assign wr_fire        = wr_valid_o && wr_ready_i;
  assign last_wr        = wr_fire && (wr_left_q == CNW'(1));
  assign rd_data_ready_o = !fifo_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      irq_q     <= 1'b0;
      rd_left_q <= '0;
      wr_left_q <= '0;
      credit_q  <= '0;
    end else begin
      irq_q <= 1'b0;
      if (start_req) begin
        if (bad_cfg) begin
          done_q <= 1'b1;
          irq_q  <= 1'b1;
        end else begin
          busy_q    <= 1'b1;
          done_q    <= 1'b0;
          rd_left_q <= total_q[31:CHUNK_SHIFT];
          wr_left_q <= total_q[31:CHUNK_SHIFT];
        end
      end else if (ctrl_wr && !reg_wdata_i[CTRL_DONE]) begin
        done_q <= 1'b0;
      end
      if (rd_fire) rd_left_q <= rd_left_q - CNW'(1);
      if (wr_fire) wr_left_q <= wr_left_q - CNW'(1);
      case ({rd_fire, wr_fire})
        2'b10:   credit_q <= credit_q + CRW'(1);
        2'b01:   credit_q <= credit_q - CRW'(1);
        default: credit_q <= credit_q;
      endcase
      if (last_wr) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        irq_q  <= 1'b1;
      end
    end
  end

  assign irq_o = irq_q;

  // address walkers: side 0 = source, side 1 = destination
  logic [AW-1:0]    walk_base [2];
  logic [GEO_W-1:0] walk_w    [2];
  logic [GEO_W-1:0] walk_g    [2];
  logic [AW-1:0]    walk_addr [2];
  logic [1:0]       walk_step;

  assign walk_base[0] = {src_q, 3'b000};
  assign walk_base[1] = {dst_q, 3'b000};
  assign walk_w[0]    = sgeo_q[GEO_W-1:0];
  assign walk_g[0]    = sgeo_q[31:GEO_W];
  assign walk_w[1]    = dgeo_q[GEO_W-1:0];
  assign walk_g[1]    = dgeo_q[31:GEO_W];
  assign walk_step    = {wr_fire, rd_fire};

  for (genvar gs = 0; gs < 2; gs++) begin : g_walk
    slc_addr_walk #(.AW(AW), .LW(GEO_W)) u_walk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (start_req && !bad_cfg),
      .base_i (walk_base[gs]),
      .width_i(walk_w[gs]),
      .gap_i  (walk_g[gs]),
      .step_i (walk_step[gs]),
      .addr_o (walk_addr[gs])
    );
  end

  assign rd_req_addr_o = walk_addr[0];
  assign wr_addr_o     = walk_addr[1];

  slc_chunk_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rd_data_valid_i),
    .data_i (rd_data_i),
    .pop_i  (wr_fire),
    .data_o (wr_data_o),
    .full_o (fifo_full),
    .empty_o(fifo_empty)
  );
endmodule

// File: rtl/slc_dma_chk.sv
module slc_dma_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 128,
  parameter int unsigned DEPTH = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       irq_o,
  input logic                       busy_i,
  input logic                       done_i,
  input logic [$clog2(DEPTH+1)-1:0] credit_i,
  input logic                       rd_req_valid_o,
  input logic                       rd_req_ready_i,
  input logic [AW-1:0]              rd_req_addr_o,
  input logic                       rd_data_valid_i,
  input logic                       rd_data_ready_o,
  input logic                       wr_valid_o,
  input logic                       wr_ready_i,
  input logic [AW-1:0]              wr_addr_o,
  input logic [DW-1:0]              wr_data_o
);
  a_r6_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r6_irq_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_i && !busy_i);
  a_r6_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i && irq_o);
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !rd_req_valid_o && !wr_valid_o);
  a_r10_credit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_i <= ($clog2(DEPTH+1))'(DEPTH));
  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_valid_i |-> rd_data_ready_o);
  a_r10_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o));
  a_r10_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));
endmodule

bind slc_dma slc_dma_chk #(.AW(AW), .DW(DW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .irq_o          (irq_o),
  .busy_i         (busy_q),
  .done_i         (done_q),
  .credit_i       (credit_q),
  .rd_req_valid_o (rd_req_valid_o),
  .rd_req_ready_i (rd_req_ready_i),
  .rd_req_addr_o  (rd_req_addr_o),
  .rd_data_valid_i(rd_data_valid_i),
  .rd_data_ready_o(rd_data_ready_o),
  .wr_valid_o     (wr_valid_o),
  .wr_ready_i     (wr_ready_i),
  .wr_addr_o      (wr_addr_o),
  .wr_data_o      (wr_data_o)
);

// File: tb/slc_dma_tb.sv
module slc_dma_tb;
  localparam int AW = 32;
  localparam int DW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = 3'd5;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;
  logic          rq_valid, rq_ready = 1'b0;
  logic [AW-1:0] rq_addr;
  logic          rd_valid = 1'b0, rd_ready;
  logic [DW-1:0] rd_data = '0;
  logic          wr_valid, wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  always #10 clk = ~clk;

  slc_dma u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq),
    .rd_req_valid_o(rq_valid), .rd_req_ready_i(rq_ready), .rd_req_addr_o(rq_addr),
    .rd_data_valid_i(rd_valid), .rd_data_i(rd_data), .rd_data_ready_o(rd_ready),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  typedef struct packed {
    logic [31:0] src, dst, total;
    logic [15:0] sw, sg, dw, dg;
    logic        stall;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h200, 32'h1000, 32'd256, 16'd4,  16'd2, 16'd8,  16'd0, 1'b0},
    '{32'h401, 32'h2003, 32'd160, 16'd3,  16'd1, 16'd2,  16'd5, 1'b1},
    '{32'h010, 32'h0800, 32'd96,  16'd1,  16'd0, 16'd1,  16'd3, 1'b1},
    '{32'h300, 32'h3000, 32'd64,  16'd16, 16'd0, 16'd16, 16'd0, 1'b0},
    '{32'h050, 32'h0060, 32'd16,  16'd5,  16'd7, 16'd2,  16'd9, 1'b1},
    '{32'h700, 32'h0900, 32'd128, 16'd2,  16'd3, 16'd8,  16'd1, 1'b0}
  };

  int total_chk = 0, bad_chk = 0;
  int rd_cnt, wr_cnt, irq_cnt, max_out, rd_aerr, wr_aerr, wr_derr, cyc = 0;
  logic stall = 1'b0;
  logic [31:0] e_src, e_dst, e_sw, e_sg, e_dw, e_dg;
  logic [AW-1:0] rq_fifo [$];

  function automatic logic [DW-1:0] fdat(input logic [31:0] a);
    return {a, a ^ 32'hA5A5_5A5A, ~a, a + 32'h1357};
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] base, w, g, input int k);
    return base + (((k / w) * (w + g)) + (k % w)) * 16;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total_chk++;
    if (act !== exp) begin
      bad_chk++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus responder and monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (irq) irq_cnt++;
      rq_ready = !(stall && (cyc % 3 == 1));
      wr_ready = !(stall && (cyc % 4 == 2));
      rd_valid = (rq_fifo.size() > 0) && !(stall && (cyc % 2 == 0));
      rd_data  = rd_valid ? fdat(rq_fifo[0]) : '0;
      #1;
      if (rd_valid && rd_ready) void'(rq_fifo.pop_front());
      if (rq_valid && rq_ready) begin
        if (rq_addr !== exp_addr(e_src, e_sw, e_sg, rd_cnt)) rd_aerr++;
        rq_fifo.push_back(rq_addr);
        rd_cnt++;
      end
      if (wr_valid && wr_ready) begin
        if (wr_addr !== exp_addr(e_dst, e_dw, e_dg, wr_cnt)) wr_aerr++;
        if (wr_data !== fdat(exp_addr(e_src, e_sw, e_sg, wr_cnt))) wr_derr++;
        wr_cnt++;
      end
      if (rd_cnt - wr_cnt > max_out) max_out = rd_cnt - wr_cnt;
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd5; reg_wdata = '0;
  endtask

  task automatic clear_mon();
    rd_cnt = 0; wr_cnt = 0; irq_cnt = 0; max_out = 0;
    rd_aerr = 0; wr_aerr = 0; wr_derr = 0;
  endtask

  task automatic setup(input vec_t v);
    e_src = v.src << 3; e_dst = v.dst << 3;
    e_sw = 32'(v.sw); e_sg = 32'(v.sg); e_dw = 32'(v.dw); e_dg = 32'(v.dg);
    stall = v.stall;
    wreg(3'd0, v.src);
    wreg(3'd1, v.dst);
    wreg(3'd2, v.total);
    wreg(3'd3, {v.sg, v.sw});
    wreg(3'd4, {v.dg, v.dw});
    clear_mon();
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (reg_rdata[8]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    bad_chk++; total_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    clear_mon();
    e_src = 0; e_dst = 0; e_sw = 1; e_sg = 0; e_dw = 1; e_dg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl", reg_rdata, 0);
    check("R1 irq/valids", {irq, rq_valid, wr_valid}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i]);
      wreg(3'd5, 32'h1);
      check("R6 busy after start", reg_rdata, 32'h1);
      wait_done();
      check("R6 done status", reg_rdata, 32'h100);
      check("R6 irq pulses", irq_cnt, 1);
      check("R2 source addresses", rd_aerr, 0);
      check("R3 dest addresses", wr_aerr, 0);
      check("R4 data", wr_derr, 0);
      check("R5 read beats", rd_cnt, VECS[i].total / 16);
      check("R5 write beats", wr_cnt, VECS[i].total / 16);
      check("R10 outstanding", max_out > 4, 0);
    end

    // R8 done clearing
    wreg(3'd5, 32'h100);
    check("R8 keep done", reg_rdata, 32'h100);
    wreg(3'd5, 32'h0);
    check("R8 clear done", reg_rdata, 32'h0);

    // R7 refusals
    setup('{32'h100, 32'h200, 32'd20, 16'd2, 16'd0, 16'd2, 16'd0, 1'b0});
    wreg(3'd5, 32'h1);
    check("R7 unaligned total done", reg_rdata, 32'h100);
    check("R7 irq first cycle", irq, 1);
    @(negedge clk);
    check("R7 irq one cycle", irq, 0);
    repeat (10) @(negedge clk);
    check("R7 no traffic", rd_cnt + wr_cnt, 0);
    wreg(3'd5, 32'h0);

    setup('{32'h100, 32'h200, 32'd64, 16'd2, 16'd0, 16'd0, 16'd1, 1'b0});
    wreg(3'd5, 32'h1);
    check("R7 zero width done", reg_rdata, 32'h100);
    repeat (10) @(negedge clk);
    check("R7 zero width no traffic", rd_cnt + wr_cnt, 0);
    wreg(3'd5, 32'h0);

    setup('{32'h100, 32'h200, 32'd0, 16'd2, 16'd0, 16'd2, 16'd0, 1'b0});
    wreg(3'd5, 32'h1);
    check("R7 zero total done", reg_rdata, 32'h100);
    repeat (10) @(negedge clk);
    check("R7 zero total no traffic/irq", {rd_cnt + wr_cnt, irq_cnt}, {32'd0, 32'd1});
    wreg(3'd5, 32'h0);

    // R9 restart while busy ignored
    setup('{32'h180, 32'h280, 32'd192, 16'd3, 16'd2, 16'd4, 16'd1, 1'b1});
    wreg(3'd5, 32'h1);
    repeat (4) @(negedge clk);
    wreg(3'd2, 32'd32);
    wreg(3'd5, 32'h1);
    check("R9 still busy", reg_rdata, 32'h1);
    wait_done();
    check("R9 beat count kept", wr_cnt, 12);
    check("R9 addresses/data", {rd_aerr, wr_aerr, wr_derr}, 0);
    check("R9 single irq", irq_cnt, 1);

    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule